// File: doc/BRIEF.md
# DMA Port-Width Sequencer

This block carries out one dual-address DMA transfer unit at a time between memory and an I/O device whose data port can be narrower than the unit. A channel is set up with a single `load` pulse. The setup gives the unit size, the I/O port width, the direction, the fixed I/O address, the starting memory address and a byte count. Each `start` pulse then moves one unit. In the I/O-to-memory direction the block issues as many narrow I/O reads as the width ratio needs. It gathers the pieces in a holding register and then writes the whole unit to memory. In the memory-to-I/O direction it reads memory first and then hands the unit out to the device piece by piece.

Every I/O cycle of a unit goes to the same address and uses only the low lanes of the I/O data bus. A 16-bit memory bus is handled by splitting a 32-bit unit into two memory accesses. Both buses use a valid/ready handshake, so wait states stall the sequencer without losing data. When the byte count runs out, the block pulses `done` and parks in a halted state until the next load.

The controller has seven states:
- IDLE: waits for a start or a load.
- IO_RD: narrow I/O reads.
- MEM_WR: memory write(s).
- MEM_RD: memory read(s).
- IO_WR: narrow I/O writes.
- UPDATE: advances the address and the count.
- HALT: count exhausted.

The transitions are:
- IDLE to IO_RD or MEM_RD on a legal start, chosen by direction.
- IDLE stays in IDLE on an illegal start.
- IO_RD to MEM_WR after the last read beat.
- MEM_RD to IO_WR after the last read access.
- MEM_WR to UPDATE after the last write access.
- IO_WR to UPDATE after the last write beat.
- UPDATE to HALT when the count reaches zero, otherwise UPDATE to IDLE.
- IDLE or HALT to IDLE on a load with a non-zero count, or to HALT on a load with a zero count.

Top module: `dma_pack_seq`

## Requirements
- R1: Size fields use a 2-bit code: `00` or `01` = 32 bits, `10` = 16 bits, `11` = 8 bits. A start with a port width larger than the unit pulses `cfg_err` for one cycle, on the cycle after start. It issues no bus cycle, leaves `busy` low and leaves the address and the count untouched.
- R2: A unit takes exactly (unit bytes / port bytes) I/O cycles: 1, 2 or 4.
- R3: Every I/O cycle uses the loaded I/O address, which never changes between loads.
- R4: I/O reads take only the low port-width bits of `io_rdata`. I/O writes drive the piece on the low lanes of `io_wdata`, with the upper bits zero.
- R5: Pieces are ordered least significant first. I/O beat k carries bits [k*w +: w] of the unit, where w is the port width.
- R6: In the I/O-to-memory direction (`cfg_dir`=0), one memory write of the whole unit follows the last I/O read. When `cfg_mem_half`=1 and the unit is 32 bits, two writes with `mem_size`=`10` go instead to addr and addr+2, carrying bits 15:0 and then 31:16 on `mem_wdata[15:0]`. Otherwise `mem_size` is the unit code, with 32 bits shown as `00`.
- R7: In the memory-to-I/O direction (`cfg_dir`=1), the memory read or reads (split the same way as R6) come first. The I/O writes then follow and present the unit's pieces.
- R8: After each unit the memory address rises by the unit bytes. The count falls by the unit bytes and goes to zero if fewer bytes remain. A load sets both to the loaded values.
- R9: When the count reaches zero, `done` is high for exactly one cycle, together with `busy` falling. Starts are then ignored until the next load.
- R10: While valid is high and ready is low, the valid, address, write flag and write data of that bus hold steady.
- R11: The I/O and memory buses are never valid in the same cycle, and all of one side's cycles of a unit finish before the other side's begin.
- R12: After reset `busy`, `done`, `cfg_err`, `io_valid`, `mem_valid` and `cur_count` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load | input | 1 | Latch channel setup (accepted in IDLE or HALT) |
| start | input | 1 | Move one transfer unit |
| cfg_dir | input | 1 | 0 = I/O to memory, 1 = memory to I/O |
| cfg_unit | input | 2 | Transfer unit size code |
| cfg_port | input | 2 | I/O port width code |
| cfg_mem_half | input | 1 | Memory bus is 16 bits wide |
| cfg_io_addr | input | AW | Fixed I/O device address |
| cfg_mem_addr | input | AW | Starting memory address |
| cfg_count | input | CW | Byte count |
| busy | output | 1 | A unit is in progress |
| done | output | 1 | One-cycle pulse when the count is exhausted |
| cfg_err | output | 1 | One-cycle pulse on an illegal start |
| cur_mem_addr | output | AW | Current memory address |
| cur_count | output | CW | Remaining byte count |
| io_valid | output | 1 | I/O bus cycle request |
| io_ready | input | 1 | I/O bus cycle accepted |
| io_write | output | 1 | I/O cycle is a write |
| io_addr | output | AW | I/O address |
| io_wdata | output | 32 | I/O write data, low lanes |
| io_rdata | input | 32 | I/O read data |
| mem_valid | output | 1 | Memory access request |
| mem_ready | input | 1 | Memory access accepted |
| mem_write | output | 1 | Memory access is a write |
| mem_addr | output | AW | Memory address of the access |
| mem_size | output | 2 | Access width code |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data |

## Verification
A wrong beat counter shows up at the end of the unit. The count of I/O or memory handshakes differs from the width ratio, and `busy` falls one or more cycles early or late. A lane in the holding register filled from the wrong beat or slice corrupts the very next memory write or I/O write data. The error shows in the same cycle that handshake completes, so it can be traced to the piece order. A slip in the address or count register is visible on `cur_mem_addr` and `cur_count` in the first idle cycle after the unit. A halted state that fails to stick shows as a bus request within one cycle of an ignored start.

// File: rtl/dps_pkg.sv
package dps_pkg;

    localparam int UNIT_BYTES = 4;
    localparam int DW = 8 * UNIT_BYTES;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_IO_RD,
        ST_MEM_WR,
        ST_MEM_RD,
        ST_IO_WR,
        ST_UPDATE,
        ST_HALT
    } seq_state_t;

    // log2 of the byte width named by a size code
    function automatic logic [1:0] size_shift(input logic [1:0] code);
        if (!code[1])
            return 2'd2;
        else if (!code[0])
            return 2'd1;
        else
            return 2'd0;
    endfunction

    function automatic logic [DW-1:0] size_mask(input logic [1:0] sh);
        logic [DW-1:0] m;
        unique case (sh)
            2'd0:    m = DW'(8'hFF);
            2'd1:    m = DW'(16'hFFFF);
            default: m = '1;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/dps_regs.sv
module dps_regs
    import dps_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic          cfg_dir,
    input  logic [1:0]    cfg_unit,
    input  logic [1:0]    cfg_port,
    input  logic          cfg_mem_half,
    input  logic [AW-1:0] cfg_io_addr,
    input  logic [AW-1:0] cfg_mem_addr,
    input  logic [CW-1:0] cfg_count,
    input  logic          advance,
    output logic          dir_q,
    output logic [1:0]    unit_q,
    output logic [1:0]    port_q,
    output logic          half_q,
    output logic [AW-1:0] io_addr_q,
    output logic [AW-1:0] mem_addr_q,
    output logic [CW-1:0] cnt_q,
    output logic          cnt_last
);

    logic [CW-1:0] unit_bytes_c;
    logic [AW-1:0] unit_step_a;

    always_comb begin
        unit_bytes_c = CW'(32'd1 << size_shift(unit_q));
        unit_step_a  = AW'(32'd1 << size_shift(unit_q));
        cnt_last     = (cnt_q <= unit_bytes_c);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q      <= 1'b0;
            unit_q     <= 2'b00;
            port_q     <= 2'b00;
            half_q     <= 1'b0;
            io_addr_q  <= '0;
            mem_addr_q <= '0;
            cnt_q      <= '0;
        end else if (cfg_we) begin
            dir_q      <= cfg_dir;
            unit_q     <= cfg_unit;
            port_q     <= cfg_port;
            half_q     <= cfg_mem_half;
            io_addr_q  <= cfg_io_addr;
            mem_addr_q <= cfg_mem_addr;
            cnt_q      <= cfg_count;
        end else if (advance) begin
            mem_addr_q <= mem_addr_q + unit_step_a;
            cnt_q      <= cnt_last ? '0 : cnt_q - unit_bytes_c;
        end
    end

endmodule

// File: rtl/dps_pack.sv
module dps_pack
    import dps_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          io_cap,
    input  logic [1:0]    io_beat,
    input  logic [1:0]    port_shift,
    input  logic [DW-1:0] io_rdata,
    input  logic          mem_cap,
    input  logic          mem_beat,
    input  logic          mem_split,
    input  logic [1:0]    unit_shift,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] io_slice,
    output logic [DW-1:0] mem_slice
);

    logic [DW-1:0] hold_q;
    logic [1:0]    port_lane_mask;
    logic [4:0]    io_sh;

    always_comb begin
        unique case (port_shift)
            2'd0:    port_lane_mask = 2'b00;
            2'd1:    port_lane_mask = 2'b01;
            default: port_lane_mask = 2'b11;
        endcase
    end

    genvar i;
    generate
        for (i = 0; i < UNIT_BYTES; i++) begin : g_lane
            localparam logic [1:0] LANE = 2'(i);
            logic       io_hit;
            logic       mem_hit;
            logic [7:0] io_byte;
            logic [7:0] mem_byte;
            logic [7:0] lane_q;

            always_comb begin
                io_hit  = io_cap && ((LANE >> port_shift) == io_beat);
                io_byte = io_rdata[8*(LANE & port_lane_mask) +: 8];
                if (mem_split) begin
                    mem_hit  = mem_cap && ((LANE >> 1) == {1'b0, mem_beat});
                    mem_byte = LANE[0] ? mem_rdata[15:8] : mem_rdata[7:0];
                end else begin
                    mem_hit  = mem_cap && ((LANE >> unit_shift) == 2'd0);
                    mem_byte = mem_rdata[8*i +: 8];
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    lane_q <= 8'h00;
                else if (clr)
                    lane_q <= 8'h00;
                else if (io_hit)
                    lane_q <= io_byte;
                else if (mem_hit)
                    lane_q <= mem_byte;
            end

            assign hold_q[8*i +: 8] = lane_q;
        end
    endgenerate

    always_comb begin
        unique case (port_shift)
            2'd0:    io_sh = {io_beat, 3'b000};
            2'd1:    io_sh = {io_beat[0], 4'b0000};
            default: io_sh = 5'd0;
        endcase
        io_slice = (hold_q >> io_sh) & size_mask(port_shift);
        if (mem_split)
            mem_slice = (hold_q >> {mem_beat, 4'b0000}) & size_mask(2'd1);
        else
            mem_slice = hold_q & size_mask(unit_shift);
    end

endmodule

// File: rtl/dps_ctrl.sv
module dps_ctrl
    import dps_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic       start,
    input  logic       dir,
    input  logic       illegal,
    input  logic       load_zero,
    input  logic       io_ready,
    input  logic       mem_ready,
    input  logic [1:0] io_last_idx,
    input  logic       mem_last_idx,
    input  logic       cnt_last,
    output logic [1:0] io_beat,
    output logic       mem_beat,
    output logic       io_valid,
    output logic       io_write,
    output logic       mem_valid,
    output logic       mem_write,
    output logic       cfg_we,
    output logic       clr_hold,
    output logic       io_cap,
    output logic       mem_cap,
    output logic       advance,
    output logic       busy,
    output logic       done,
    output logic       cfg_err
);

    seq_state_t state_q, state_d;
    logic [1:0] io_beat_q, io_beat_d;
    logic       mem_beat_q, mem_beat_d;
    logic       done_q, done_d;
    logic       err_q, err_d;
    logic       parked;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            io_beat_q  <= 2'd0;
            mem_beat_q <= 1'b0;
            done_q     <= 1'b0;
            err_q      <= 1'b0;
        end else begin
            state_q    <= state_d;
            io_beat_q  <= io_beat_d;
            mem_beat_q <= mem_beat_d;
            done_q     <= done_d;
            err_q      <= err_d;
        end
    end

    // next state
    always_comb begin
        state_d    = state_q;
        io_beat_d  = io_beat_q;
        mem_beat_d = mem_beat_q;
        done_d     = 1'b0;
        err_d      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (load) begin
                    state_d = load_zero ? ST_HALT : ST_IDLE;
                end else if (start) begin
                    if (illegal) begin
                        err_d = 1'b1;
                    end else begin
                        state_d    = dir ? ST_MEM_RD : ST_IO_RD;
                        io_beat_d  = 2'd0;
                        mem_beat_d = 1'b0;
                    end
                end
            end
            ST_IO_RD, ST_IO_WR: begin
                if (io_ready) begin
                    if (io_beat_q == io_last_idx) begin
                        io_beat_d = 2'd0;
                        state_d   = (state_q == ST_IO_RD) ? ST_MEM_WR : ST_UPDATE;
                    end else begin
                        io_beat_d = io_beat_q + 2'd1;
                    end
                end
            end
            ST_MEM_RD, ST_MEM_WR: begin
                if (mem_ready) begin
                    if (mem_beat_q == mem_last_idx) begin
                        mem_beat_d = 1'b0;
                        state_d    = (state_q == ST_MEM_RD) ? ST_IO_WR : ST_UPDATE;
                    end else begin
                        mem_beat_d = 1'b1;
                    end
                end
            end
            ST_UPDATE: begin
                state_d = cnt_last ? ST_HALT : ST_IDLE;
                done_d  = cnt_last;
            end
            ST_HALT: begin
                if (load)
                    state_d = load_zero ? ST_HALT : ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        parked    = (state_q == ST_IDLE) || (state_q == ST_HALT);
        io_valid  = (state_q == ST_IO_RD) || (state_q == ST_IO_WR);
        io_write  = (state_q == ST_IO_WR);
        mem_valid = (state_q == ST_MEM_RD) || (state_q == ST_MEM_WR);
        mem_write = (state_q == ST_MEM_WR);
        cfg_we    = load && parked;
        clr_hold  = (state_q == ST_IDLE) && !load && start && !illegal;
        io_cap    = (state_q == ST_IO_RD) && io_ready;
        mem_cap   = (state_q == ST_MEM_RD) && mem_ready;
        advance   = (state_q == ST_UPDATE);
        busy      = !parked;
        done      = done_q;
        cfg_err   = err_q;
        io_beat   = io_beat_q;
        mem_beat  = mem_beat_q;
    end

endmodule

// File: rtl/dma_pack_seq.sv
module dma_pack_seq
    import dps_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          start,
    input  logic          cfg_dir,
    input  logic [1:0]    cfg_unit,
    input  logic [1:0]    cfg_port,
    input  logic          cfg_mem_half,
    input  logic [AW-1:0] cfg_io_addr,
    input  logic [AW-1:0] cfg_mem_addr,
    input  logic [CW-1:0] cfg_count,
    output logic          busy,
    output logic          done,
    output logic          cfg_err,
    output logic [AW-1:0] cur_mem_addr,
    output logic [CW-1:0] cur_count,
    output logic          io_valid,
    input  logic          io_ready,
    output logic          io_write,
    output logic [AW-1:0] io_addr,
    output logic [DW-1:0] io_wdata,
    input  logic [DW-1:0] io_rdata,
    output logic          mem_valid,
    input  logic          mem_ready,
    output logic          mem_write,
    output logic [AW-1:0] mem_addr,
    output logic [1:0]    mem_size,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata
);

    logic          dir_q, half_q, cnt_last;
    logic [1:0]    unit_q, port_q;
    logic [AW-1:0] io_addr_q, mem_addr_q;
    logic [CW-1:0] cnt_q;
    logic [1:0]    unit_sh, port_sh, io_last_idx, io_beat;
    logic          illegal, mem_split, mem_beat;
    logic          cfg_we, clr_hold, io_cap, mem_cap, advance;
    logic [DW-1:0] io_slice, mem_slice;

    always_comb begin
        unit_sh   = size_shift(unit_q);
        port_sh   = size_shift(port_q);
        illegal   = port_sh > unit_sh;
        mem_split = half_q && (unit_sh == 2'd2);
        unique case (unit_sh - port_sh)
            2'd0:    io_last_idx = 2'd0;
            2'd1:    io_last_idx = 2'd1;
            default: io_last_idx = 2'd3;
        endcase
    end

    dps_regs #(.AW(AW), .CW(CW)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_dir      (cfg_dir),
        .cfg_unit     (cfg_unit),
        .cfg_port     (cfg_port),
        .cfg_mem_half (cfg_mem_half),
        .cfg_io_addr  (cfg_io_addr),
        .cfg_mem_addr (cfg_mem_addr),
        .cfg_count    (cfg_count),
        .advance      (advance),
        .dir_q        (dir_q),
        .unit_q       (unit_q),
        .port_q       (port_q),
        .half_q       (half_q),
        .io_addr_q    (io_addr_q),
        .mem_addr_q   (mem_addr_q),
        .cnt_q        (cnt_q),
        .cnt_last     (cnt_last)
    );

    dps_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (load),
        .start        (start),
        .dir          (dir_q),
        .illegal      (illegal),
        .load_zero    (cfg_count == '0),
        .io_ready     (io_ready),
        .mem_ready    (mem_ready),
        .io_last_idx  (io_last_idx),
        .mem_last_idx (mem_split),
        .cnt_last     (cnt_last),
        .io_beat      (io_beat),
        .mem_beat     (mem_beat),
        .io_valid     (io_valid),
        .io_write     (io_write),
        .mem_valid    (mem_valid),
        .mem_write    (mem_write),
        .cfg_we       (cfg_we),
        .clr_hold     (clr_hold),
        .io_cap       (io_cap),
        .mem_cap      (mem_cap),
        .advance      (advance),
        .busy         (busy),
        .done         (done),
        .cfg_err      (cfg_err)
    );

    dps_pack u_pack (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr_hold),
        .io_cap     (io_cap),
        .io_beat    (io_beat),
        .port_shift (port_sh),
        .io_rdata   (io_rdata),
        .mem_cap    (mem_cap),
        .mem_beat   (mem_beat),
        .mem_split  (mem_split),
        .unit_shift (unit_sh),
        .mem_rdata  (mem_rdata),
        .io_slice   (io_slice),
        .mem_slice  (mem_slice)
    );

    always_comb begin
        io_addr      = io_addr_q;
        io_wdata     = io_write ? io_slice : '0;
        mem_addr     = mem_addr_q + (mem_beat ? AW'(2) : AW'(0));
        mem_size     = mem_split ? 2'b10 : (unit_q[1] ? unit_q : 2'b00);
        mem_wdata    = mem_write ? mem_slice : '0;
        cur_mem_addr = mem_addr_q;
        cur_count    = cnt_q;
    end

endmodule

// File: rtl/dps_checker.sv
module dps_checker #(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          load,
    input logic          busy,
    input logic          done,
    input logic          cfg_err,
    input logic [CW-1:0] cur_count,
    input logic          io_valid,
    input logic          io_ready,
    input logic          io_write,
    input logic [AW-1:0] io_addr,
    input logic [31:0]   io_wdata,
    input logic          mem_valid,
    input logic          mem_ready,
    input logic          mem_write,
    input logic [AW-1:0] mem_addr,
    input logic [31:0]   mem_wdata
);

    p_io_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        io_valid && !io_ready |=> io_valid && $stable(io_write) && $stable(io_addr) && $stable(io_wdata));

    p_mem_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_write) && $stable(mem_addr) && $stable(mem_wdata));

    p_one_bus_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_valid && mem_valid));

    p_err_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !busy && !io_valid && !mem_valid);

    p_done_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cur_count == '0) && !busy);

    p_count_down_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> cur_count <= $past(cur_count));

    p_io_addr_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(io_addr));

endmodule

bind dma_pack_seq dps_checker #(.AW(AW), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .busy      (busy),
    .done      (done),
    .cfg_err   (cfg_err),
    .cur_count (cur_count),
    .io_valid  (io_valid),
    .io_ready  (io_ready),
    .io_write  (io_write),
    .io_addr   (io_addr),
    .io_wdata  (io_wdata),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_write (mem_write),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
);

// File: tb/dma_pack_seq_test.sv
module dma_pack_seq_test;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int AW = 32;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load, start, cfg_dir, cfg_mem_half;
    logic [1:0]    cfg_unit, cfg_port;
    logic [AW-1:0] cfg_io_addr, cfg_mem_addr;
    logic [CW-1:0] cfg_count;
    logic          busy, done, cfg_err;
    logic [AW-1:0] cur_mem_addr;
    logic [CW-1:0] cur_count;
    logic          io_valid, io_ready, io_write;
    logic [AW-1:0] io_addr;
    logic [31:0]   io_wdata, io_rdata;
    logic          mem_valid, mem_ready, mem_write;
    logic [AW-1:0] mem_addr;
    logic [1:0]    mem_size;
    logic [31:0]   mem_wdata, mem_rdata;

    int n_chk = 0;
    int n_fail = 0;

    logic          m_dir, m_half;
    logic [1:0]    m_unit, m_port;
    logic [AW-1:0] m_ioa, m_mema;
    logic [CW-1:0] m_cnt;

    always #2.5 clk = ~clk;

    dma_pack_seq #(.AW(AW), .CW(CW)) uut (.*);

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int fb(input logic [1:0] code);
        return code[1] ? (code[0] ? 1 : 2) : 4;
    endfunction

    function automatic logic [31:0] fmask(input int nbytes);
        return (nbytes == 4) ? 32'hFFFF_FFFF : ((32'd1 << (8 * nbytes)) - 32'd1);
    endfunction

    task automatic do_load(input logic dir, input logic [1:0] unit, input logic [1:0] port,
                           input logic half, input logic [AW-1:0] ioa,
                           input logic [AW-1:0] mema, input logic [CW-1:0] cnt);
        @(negedge clk);
        load = 1'b1; cfg_dir = dir; cfg_unit = unit; cfg_port = port;
        cfg_mem_half = half; cfg_io_addr = ioa; cfg_mem_addr = mema; cfg_count = cnt;
        @(negedge clk);
        load = 1'b0;
        m_dir = dir; m_unit = unit; m_port = port; m_half = half;
        m_ioa = ioa; m_mema = mema; m_cnt = cnt;
        chk(cur_count == cnt, "R8 load count", 64'(cur_count), 64'(cnt));
        chk(cur_mem_addr == mema, "R8 load addr", 64'(cur_mem_addr), 64'(mema));
    endtask

    task automatic run_unit();
        int ub, pb, nio, nmem, io_n, mem_n, guard;
        bit split, last;
        logic [31:0] eu, v, ex;
        logic [1:0] esz;
        ub = fb(m_unit); pb = fb(m_port); nio = ub / pb;
        split = m_half && (ub == 4); nmem = split ? 2 : 1;
        esz = split ? 2'b10 : (m_unit[1] ? m_unit : 2'b00);
        last = (m_cnt <= CW'(ub));
        io_n = 0; mem_n = 0; guard = 0; eu = 32'd0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        while (busy && guard < 400) begin
            io_ready = 1'b0; mem_ready = 1'b0;
            io_rdata = $urandom; mem_rdata = $urandom;
            if (io_valid) begin
                chk(io_addr == m_ioa, "R3 io address", 64'(io_addr), 64'(m_ioa));
                chk(io_write == m_dir, "R7 io direction", 64'(io_write), 64'(m_dir));
                chk(mem_n == (m_dir ? nmem : 0), "R11 side order io", 64'(mem_n), 64'(m_dir ? nmem : 0));
                if ($urandom % 4 != 0) begin
                    io_ready = 1'b1;
                    if (!io_write) begin
                        v = $urandom; io_rdata = v;
                        eu = eu | ((v & fmask(pb)) << (8 * pb * io_n));
                    end else begin
                        ex = (eu >> (8 * pb * io_n)) & fmask(pb);
                        chk(io_wdata == ex, "R4 R5 io write slice", 64'(io_wdata), 64'(ex));
                    end
                    io_n++;
                end
            end
            if (mem_valid) begin
                chk(mem_write == !m_dir, "R6 mem direction", 64'(mem_write), 64'(!m_dir));
                chk(mem_addr == m_mema + AW'(2 * mem_n), "R6 mem address", 64'(mem_addr), 64'(m_mema + AW'(2 * mem_n)));
                chk(mem_size == esz, "R6 mem size", 64'(mem_size), 64'(esz));
                chk(io_n == (m_dir ? 0 : nio), "R11 side order mem", 64'(io_n), 64'(m_dir ? 0 : nio));
                if ($urandom % 4 != 0) begin
                    mem_ready = 1'b1;
                    if (mem_write) begin
                        ex = split ? ((eu >> (16 * mem_n)) & 32'hFFFF) : eu;
                        chk(mem_wdata == ex, "R6 mem write data", 64'(mem_wdata), 64'(ex));
                    end else begin
                        v = $urandom; mem_rdata = v;
                        if (split) eu = eu | ((v & 32'hFFFF) << (16 * mem_n));
                        else eu = v & fmask(ub);
                    end
                    mem_n++;
                end
            end
            @(negedge clk);
            guard++;
        end
        io_ready = 1'b0; mem_ready = 1'b0;
        chk(guard < 400, "R10 unit completes", 64'(guard), 64'(400));
        chk(io_n == nio, "R2 io cycle count", 64'(io_n), 64'(nio));
        chk(mem_n == nmem, "R6 R7 mem access count", 64'(mem_n), 64'(nmem));
        m_mema = m_mema + AW'(ub);
        m_cnt = last ? '0 : m_cnt - CW'(ub);
        chk(cur_mem_addr == m_mema, "R8 addr step", 64'(cur_mem_addr), 64'(m_mema));
        chk(cur_count == m_cnt, "R8 count step", 64'(cur_count), 64'(m_cnt));
        chk(done == last, "R9 done pulse", 64'(done), 64'(last));
        if (last) begin
            @(negedge clk);
            chk(done == 1'b0, "R9 done one cycle", 64'(done), 64'd0);
        end
    endtask

    task automatic run_all();
        int n;
        n = 0;
        while (m_cnt != '0 && n < 8) begin
            run_unit();
            n++;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        load = 0; start = 0; cfg_dir = 0; cfg_mem_half = 0; cfg_unit = 0; cfg_port = 0;
        cfg_io_addr = 0; cfg_mem_addr = 0; cfg_count = 0;
        io_ready = 0; mem_ready = 0; io_rdata = 0; mem_rdata = 0;
        repeat (4) @(negedge clk);
        chk(busy == 0 && done == 0 && cfg_err == 0, "R12 reset flags", {busy, done, cfg_err}, 0);
        chk(io_valid == 0 && mem_valid == 0, "R12 reset valids", {io_valid, mem_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cur_count == 0, "R12 reset count", 64'(cur_count), 0);

        // R2 R5 R6: 32-bit unit over 8-bit port into 32-bit memory
        do_load(1'b0, 2'b00, 2'b11, 1'b0, 32'h0000_4000, 32'h1000_0000, 16'd8);
        run_all();
        // R6: 32-bit unit over 16-bit port, 16-bit memory bus
        do_load(1'b0, 2'b00, 2'b10, 1'b1, 32'h0000_4010, 32'h1000_0100, 16'd4);
        run_all();
        // R7: memory to 8-bit port, 16-bit memory bus
        do_load(1'b1, 2'b00, 2'b11, 1'b1, 32'h0000_4020, 32'h1000_0200, 16'd4);
        run_all();
        // R7: 16-bit unit to 8-bit port
        do_load(1'b1, 2'b10, 2'b11, 1'b0, 32'h0000_4030, 32'h1000_0300, 16'd4);
        run_all();
        // R1 R8: code 01 means 32 bits; count 6 saturates to zero
        do_load(1'b0, 2'b01, 2'b00, 1'b0, 32'h0000_4040, 32'h1000_0400, 16'd6);
        run_all();

        // R9: starts ignored after done
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(busy == 0 && io_valid == 0 && mem_valid == 0, "R9 halted ignores start",
            {busy, io_valid, mem_valid}, 0);
        @(negedge clk);
        chk(cur_count == 0 && cur_mem_addr == m_mema, "R9 halted state kept", 64'(cur_mem_addr), 64'(m_mema));

        // R1: port wider than unit is rejected
        do_load(1'b0, 2'b11, 2'b10, 1'b0, 32'h0000_4050, 32'h1000_0500, 16'd8);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(cfg_err == 1'b1, "R1 illegal flagged", 64'(cfg_err), 1);
        chk(busy == 0 && io_valid == 0 && mem_valid == 0, "R1 illegal no start",
            {busy, io_valid, mem_valid}, 0);
        @(negedge clk);
        chk(cfg_err == 1'b0, "R1 error one cycle", 64'(cfg_err), 0);
        chk(cur_count == 16'd8 && cur_mem_addr == 32'h1000_0500, "R1 illegal no update",
            64'(cur_count), 64'd8);

        // random legal settings
        for (int k = 0; k < 40; k++) begin
            logic [1:0] u, p;
            int ub;
            u = 2'($urandom);
            do p = 2'($urandom); while (fb(p) > fb(u));
            ub = fb(u);
            do_load(1'($urandom), u, p, 1'($urandom), $urandom, $urandom & 32'hFFFF_FFF0,
                    CW'(ub * (1 + $urandom % 3) - ($urandom % 2)));
            run_all();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule